// File: doc/BRIEF.md
# Task and Event Driven UART Control Block

This block is the register-side controller of a byte-wide serial port. Software talks to it through a simple 32-bit register bus. Writing 1 to a task register starts or stops the transmit and receive directions. Event registers record what has happened: a byte was received, a byte was sent, a line break was seen, or reception was stopped. An interrupt mask chooses which events drive the interrupt line. The mask can be written directly, or bits can be set or cleared through two alias addresses. Received bytes wait in a small circular FIFO and are read one at a time through a data-read register. A byte to send is written to a data-write register and held until the serial side takes it.

The serial side exchanges whole bytes only. Bit timing, baud generation and pin routing belong to neighbouring blocks. The block keeps four pin-select words and a baud word as plain storage for those neighbours.

Handshake rules on the serial side:
- **Transmit:** `tx_valid` with `tx_data` is a valid/ready source. Once `tx_valid` is raised, it and `tx_data` stay unchanged until a cycle in which `tx_ready` is high. That cycle completes the transfer.
- **Receive:** `rx_ready` is the block's back-pressure. A byte offered with `rx_valid` in a cycle when `rx_ready` is low is discarded, not stalled.

The bus is single-cycle. `bus_rdata` is combinational from the address during a `bus_rd` cycle. Side effects of a read or write (for example a FIFO pop) take place at the clock edge that ends that cycle.

Top module: `uart_task_ctrl`

Register map (byte addresses):

| Address | Register |
|---|---|
| 0x00 | START_RX |
| 0x04 | STOP_RX |
| 0x08 | START_TX |
| 0x0C | STOP_TX |
| 0x10 | SUSPEND |
| 0x20 | EV_RXRDY |
| 0x24 | EV_TXRDY |
| 0x28 | EV_ERROR |
| 0x2C | EV_RXTO |
| 0x40 | IRQ_MASK |
| 0x44 | IRQ_SET |
| 0x48 | IRQ_CLR |
| 0x50 | ERR_SRC |
| 0x60 | ENABLE |
| 0x70 | RXD |
| 0x74 | TXD |
| 0x80, 0x84, 0x88, 0x8C | PIN0 to PIN3 |
| 0x90 | BAUD |

Interrupt mask and event bit order: bit 0 RX-ready, bit 1 TX-ready, bit 2 error, bit 3 RX-timeout.

## Requirements
- R1: A write of 4 to ENABLE (0x60) enables the block. A write of any other nonzero value leaves the enable state unchanged. A write of 0 disables it. ENABLE reads 4 while enabled.
- R2: A write of 0 to ENABLE also stops transmit and receive and sets the RX-timeout event. After re-enabling, TXD writes are refused and `rx_ready` stays low until the start tasks are issued again.
- R3: While disabled, every read returns 0, and every write except one to ENABLE has no effect.
- R4: `irq` is high exactly when some event bit is set and its mask bit (bit 0 RX-ready, bit 1 TX-ready, bit 2 error, bit 3 RX-timeout) is set.
- R5: IRQ_MASK (0x40) takes bits [3:0] as written. IRQ_SET (0x44) ORs the written bits into the mask. IRQ_CLR (0x48) clears the written bits. A read of any of the three returns the mask.
- R6: A TXD (0x74) write is taken only while transmit is started and no byte is waiting. The byte appears on `tx_data` with `tx_valid` and stays stable until `tx_ready`. That transfer clears `tx_valid` and sets the TX-ready event.
- R7: `rx_ready` is high while receive is started and the 8-entry FIFO is not full. A byte offered while `rx_ready` is high is stored and sets the RX-ready event. A byte offered while it is low is dropped.
- R8: A read of RXD (0x70) returns the byte at the FIFO head. When receive is started and the FIFO is not empty, the read removes that byte. If bytes remain after the removal, the RX-ready event is set again.
- R9: Writing exactly 1 to START_RX (0x00) or START_TX (0x08) starts that direction. STOP_RX (0x04) stops receive and sets the RX-timeout event. STOP_TX (0x0C) stops transmit. SUSPEND (0x10) stops both and sets the RX-timeout event. Other values do nothing.
- R10: A cycle with `brk` high sets ERR_SRC (0x50) bits [1:0] to 11 and sets the error event. A write to ERR_SRC clears the bits written as 1.
- R11: EV_RXRDY (0x20) can only be cleared, by writing 0; nonzero writes are ignored. The other three event registers are set by a nonzero write and cleared by a zero write. Writes to RXD are ignored. A hardware set beats a bus write in the same cycle.
- R12: After reset, PIN0 to PIN3 (0x80 to 0x8C) read 0xFFFFFFFF and BAUD (0x90) reads 0x04000000 once enabled. All other registers, the FIFO, the started flags and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serial side takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Block can store a received byte |
| rx_data | input | 8 | Received byte |
| brk | input | 1 | Line break detected |

## Verification
A wrong FIFO pointer or count shows up at the next RXD read, either as a byte out of arrival order or as a missing byte. It also shows up as `rx_ready` falling at the wrong fill level, which a scoreboard of accepted bytes catches on the next push or pop. A lost or stuck pending flag shows on the transmit port within one cycle: a second byte overwrites the first, or a handshake happens that the scoreboard did not expect. Event and mask errors appear on `irq` one clock after the write that should have changed them. Enable-gating faults appear on the first read while disabled.

// File: rtl/utc_pkg.sv
package utc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_START_RX = 8'h00;
  localparam logic [ADDR_W-1:0] A_STOP_RX  = 8'h04;
  localparam logic [ADDR_W-1:0] A_START_TX = 8'h08;
  localparam logic [ADDR_W-1:0] A_STOP_TX  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_SUSPEND  = 8'h10;
  localparam logic [ADDR_W-1:0] A_EV_RXRDY = 8'h20;
  localparam logic [ADDR_W-1:0] A_EV_TXRDY = 8'h24;
  localparam logic [ADDR_W-1:0] A_EV_ERROR = 8'h28;
  localparam logic [ADDR_W-1:0] A_EV_RXTO  = 8'h2C;
  localparam logic [ADDR_W-1:0] A_IRQ_MASK = 8'h40;
  localparam logic [ADDR_W-1:0] A_IRQ_SET  = 8'h44;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 8'h48;
  localparam logic [ADDR_W-1:0] A_ERR_SRC  = 8'h50;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 8'h60;
  localparam logic [ADDR_W-1:0] A_RXD      = 8'h70;
  localparam logic [ADDR_W-1:0] A_TXD      = 8'h74;
  localparam logic [ADDR_W-1:0] A_PIN0     = 8'h80;
  localparam logic [ADDR_W-1:0] A_BAUD     = 8'h90;

  // event / mask bit order
  localparam int EV_RXRDY = 0;
  localparam int EV_TXRDY = 1;
  localparam int EV_ERROR = 2;
  localparam int EV_RXTO  = 3;
  localparam int NUM_EV   = 4;

  localparam int NUM_PIN  = 4;
  localparam int ERR_W    = 2;

  localparam logic [DATA_W-1:0] ENABLE_CODE = 32'd4;
  localparam logic [DATA_W-1:0] PIN_RESET   = 32'hFFFF_FFFF;
  localparam logic [DATA_W-1:0] BAUD_RESET  = 32'h0400_0000;

  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/utc_rx_fifo.sv
module utc_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the controller never offers a byte to a full FIFO
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: a pop only happens with data present
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/utc_tx_hold.sv
module utc_tx_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [WIDTH-1:0] tx_data,
  output logic             done
);
  assign done = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_data;
    end else if (done) begin
      tx_valid <= 1'b0;
    end
  end

  // R6: an offered byte is held until taken
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R6: a new byte is loaded only into an empty holder
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !tx_valid);
endmodule

// File: rtl/utc_irq_merge.sv
module utc_irq_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] events,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = events[i] & mask[i];
  end
  assign irq = |hit;
endmodule

// File: rtl/uart_task_ctrl.sv
module uart_task_ctrl
  import utc_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              brk
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic enabled, rx_started, tx_started;
  ev_vec_t ev_q, ev_set, ev_wr, ev_wval;
  logic [NUM_EV-1:0] mask_q;
  logic [ERR_W-1:0] err_q;
  logic [DATA_W-1:0] pin_q [NUM_PIN];
  logic [DATA_W-1:0] baud_q;

  logic wr, one, en_wr, en_off, stop_rx, stop_tx, start_rx, start_tx;
  logic rd_rxd, pop, push, tx_load, tx_done;
  logic [BYTE_W-1:0] fifo_head;
  logic [CNT_W-1:0] fifo_count;
  logic fifo_full, fifo_empty;

  assign wr       = bus_wr && enabled;
  assign one      = (bus_wdata == 32'd1);
  assign en_wr    = bus_wr && (bus_addr == A_ENABLE);
  assign en_off   = en_wr && (bus_wdata == '0);
  assign start_rx = wr && (bus_addr == A_START_RX) && one;
  assign start_tx = wr && (bus_addr == A_START_TX) && one;
  assign stop_rx  = en_off || (wr && one && (bus_addr == A_STOP_RX || bus_addr == A_SUSPEND));
  assign stop_tx  = en_off || (wr && one && (bus_addr == A_STOP_TX || bus_addr == A_SUSPEND));

  assign rd_rxd   = bus_rd && enabled && (bus_addr == A_RXD);
  assign pop      = rd_rxd && rx_started && !fifo_empty;
  assign rx_ready = rx_started && !fifo_full;
  assign push     = rx_valid && rx_ready;
  assign tx_load  = wr && (bus_addr == A_TXD) && tx_started && !tx_valid;

  utc_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_data), .pop(pop),
    .head(fifo_head), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  utc_tx_hold #(.WIDTH(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(bus_wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .done(tx_done)
  );

  utc_irq_merge #(.N(NUM_EV)) u_irq (.events(ev_q), .mask(mask_q), .irq(irq));

  // state flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled    <= 1'b0;
      rx_started <= 1'b0;
      tx_started <= 1'b0;
    end else begin
      if (en_off) enabled <= 1'b0;
      else if (en_wr && bus_wdata == ENABLE_CODE) enabled <= 1'b1;
      if (stop_rx) rx_started <= 1'b0;
      else if (start_rx) rx_started <= 1'b1;
      if (stop_tx) tx_started <= 1'b0;
      else if (start_tx) tx_started <= 1'b1;
    end
  end

  // event sources and bus write rules
  always_comb begin
    ev_set = '0;
    ev_set[EV_RXRDY] = push || (pop && fifo_count > CNT_W'(1));
    ev_set[EV_TXRDY] = tx_done;
    ev_set[EV_ERROR] = brk;
    ev_set[EV_RXTO]  = stop_rx;
    ev_wr = '0;
    ev_wr[EV_RXRDY] = wr && (bus_addr == A_EV_RXRDY) && (bus_wdata == '0);
    ev_wr[EV_TXRDY] = wr && (bus_addr == A_EV_TXRDY);
    ev_wr[EV_ERROR] = wr && (bus_addr == A_EV_ERROR);
    ev_wr[EV_RXTO]  = wr && (bus_addr == A_EV_RXTO);
    ev_wval = {NUM_EV{bus_wdata != '0}};
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ev_q[i] <= 1'b0;
      else if (ev_set[i]) ev_q[i] <= 1'b1;
      else if (ev_wr[i])  ev_q[i] <= ev_wval[i];
    end
  end

  // mask, error source, baud
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      err_q  <= '0;
      baud_q <= BAUD_RESET;
    end else begin
      if (wr && bus_addr == A_IRQ_MASK) mask_q <= bus_wdata[NUM_EV-1:0];
      else if (wr && bus_addr == A_IRQ_SET) mask_q <= mask_q | bus_wdata[NUM_EV-1:0];
      else if (wr && bus_addr == A_IRQ_CLR) mask_q <= mask_q & ~bus_wdata[NUM_EV-1:0];
      if (brk) err_q <= '1;
      else if (wr && bus_addr == A_ERR_SRC) err_q <= err_q & ~bus_wdata[ERR_W-1:0];
      if (wr && bus_addr == A_BAUD) baud_q <= bus_wdata;
    end
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] PADR = A_PIN0 + ADDR_W'(4*p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[p] <= PIN_RESET;
      else if (wr && bus_addr == PADR) pin_q[p] <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (enabled) begin
      case (bus_addr)
        A_EV_RXRDY: bus_rdata = DATA_W'(ev_q[EV_RXRDY]);
        A_EV_TXRDY: bus_rdata = DATA_W'(ev_q[EV_TXRDY]);
        A_EV_ERROR: bus_rdata = DATA_W'(ev_q[EV_ERROR]);
        A_EV_RXTO:  bus_rdata = DATA_W'(ev_q[EV_RXTO]);
        A_IRQ_MASK, A_IRQ_SET, A_IRQ_CLR: bus_rdata = DATA_W'(mask_q);
        A_ERR_SRC:  bus_rdata = DATA_W'(err_q);
        A_ENABLE:   bus_rdata = ENABLE_CODE;
        A_RXD:      bus_rdata = DATA_W'(fifo_head);
        A_BAUD:     bus_rdata = baud_q;
        default:    bus_rdata = '0;
      endcase
      for (int p = 0; p < NUM_PIN; p++)
        if (bus_addr == A_PIN0 + ADDR_W'(4*p)) bus_rdata = pin_q[p];
    end
  end

  // R1: enabling needs the exact code
  a_r1_enable_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled) |-> $past(bus_wr && bus_addr == A_ENABLE && bus_wdata == ENABLE_CODE));
  // R3: a disabled block keeps its mask whatever is written elsewhere
  a_r3_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && bus_wr && bus_addr != A_ENABLE) |=> $stable(mask_q));
  // R2: disabling leaves both directions stopped and the timeout event set
  a_r2_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    en_off |=> (!rx_ready && !tx_started && ev_q[EV_RXTO]));
  // R10: a break always leaves both error source bits set
  a_r10_break_flags: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (err_q == '1 && ev_q[EV_ERROR]));
endmodule

// File: tb/uart_task_ctrl_tb.sv
module uart_task_ctrl_tb;
  import utc_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, brk = 0;
  logic [7:0] tx_data, rx_data = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_task_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .brk(brk)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // driver: records what the design must store
  task automatic push_rx(logic [7:0] b);
    @(negedge clk);
    if (rx_ready) rx_q.push_back(b);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  task automatic pop_rx(string req);
    logic [31:0] d;
    logic [7:0] e;
    rd(A_RXD, d);
    e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
    chk(req, d, {24'h0, e});
  endtask

  task automatic send_tx(logic [7:0] b, bit take);
    if (take) tx_q.push_back(b);
    wr(A_TXD, {24'h0, b});
  endtask

  task automatic port_chk(string req, logic act, logic exp);
    @(negedge clk); chk(req, {31'h0, act}, {31'h0, exp});
  endtask

  // monitor: compares bytes leaving the transmit port
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6 actual=%h expected=none", tx_data);
      end else chk("R6 tx scoreboard", {24'h0, tx_data}, {24'h0, tx_q.pop_front()});
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12 reset state on the ports
    port_chk("R12 irq", irq, 0);
    port_chk("R12 tx_valid", tx_valid, 0);
    port_chk("R12 rx_ready", rx_ready, 0);
    // R3 disabled block
    rd_chk("R3 read while disabled", A_BAUD, 0);
    wr(A_IRQ_SET, 32'hF);
    // R1 wrong code
    wr(A_ENABLE, 5);
    rd_chk("R1 code 5 keeps disabled", A_BAUD, 0);
    wr(A_ENABLE, 4);
    rd_chk("R1 enable reads 4", A_ENABLE, 4);
    rd_chk("R12 baud", A_BAUD, 32'h0400_0000);
    for (int p = 0; p < 4; p++) rd_chk("R12 pin", A_PIN0 + 8'(4*p), 32'hFFFF_FFFF);
    rd_chk("R3 mask write ignored", A_IRQ_MASK, 0);
    rd_chk("R12 errsrc", A_ERR_SRC, 0);
    rd_chk("R12 rxto", A_EV_RXTO, 0);
    wr(A_ENABLE, 9);
    rd_chk("R1 nonzero keeps enabled", A_ENABLE, 4);
    // R5 mask aliases
    wr(A_IRQ_SET, 5);  rd_chk("R5 set", A_IRQ_MASK, 5);
    wr(A_IRQ_SET, 2);  rd_chk("R5 set alias read", A_IRQ_SET, 7);
    wr(A_IRQ_CLR, 1);  rd_chk("R5 clr alias read", A_IRQ_CLR, 6);
    wr(A_IRQ_MASK, 0); rd_chk("R5 plain", A_IRQ_MASK, 0);
    // R4 interrupt combine
    wr(A_EV_TXRDY, 1);  port_chk("R4 masked", irq, 0);
    wr(A_IRQ_SET, 2);   port_chk("R4 unmasked", irq, 1);
    wr(A_IRQ_CLR, 2);   port_chk("R4 cleared mask", irq, 0);
    wr(A_EV_TXRDY, 0);  rd_chk("R11 txrdy cleared", A_EV_TXRDY, 0);
    // R6 transmit
    send_tx(8'hA5, 0);  port_chk("R6 not started", tx_valid, 0);
    wr(A_START_TX, 1);
    send_tx(8'hA5, 1);  port_chk("R6 offered", tx_valid, 1);
    chk("R6 data", {24'h0, tx_data}, 32'hA5);
    send_tx(8'h3C, 0);
    repeat (3) @(posedge clk);
    chk("R6 held", {24'h0, tx_data}, 32'hA5);
    @(posedge clk); #1 tx_ready = 1;
    repeat (2) @(posedge clk);
    port_chk("R6 taken", tx_valid, 0);
    rd_chk("R6 txrdy event", A_EV_TXRDY, 1);
    send_tx(8'h3C, 1);
    repeat (3) @(posedge clk);
    chk("R6 all sent", tx_q.size(), 0);
    wr(A_IRQ_SET, 2); port_chk("R4 tx event irq", irq, 1);
    wr(A_IRQ_MASK, 0); wr(A_EV_TXRDY, 0);
    // R7 receive
    push_rx(8'h55);
    port_chk("R7 not started", rx_ready, 0);
    rd_chk("R7 dropped no event", A_EV_RXRDY, 0);
    wr(A_START_RX, 1);
    port_chk("R7 ready", rx_ready, 1);
    for (int i = 0; i < 8; i++) push_rx(8'h10 + 8'(i));
    port_chk("R7 full", rx_ready, 0);
    push_rx(8'h99);
    rd_chk("R7 rxrdy event", A_EV_RXRDY, 1);
    // R11 rxrdy clear only
    wr(A_EV_RXRDY, 0); rd_chk("R11 clear", A_EV_RXRDY, 0);
    wr(A_EV_RXRDY, 1); rd_chk("R11 set ignored", A_EV_RXRDY, 0);
    wr(A_RXD, 32'h77);
    // R8 pops
    pop_rx("R8 first byte");
    rd_chk("R8 re-raise", A_EV_RXRDY, 1);
    for (int i = 0; i < 6; i++) pop_rx("R8 byte");
    wr(A_EV_RXRDY, 0);
    pop_rx("R8 last byte");
    rd_chk("R8 no re-raise when empty", A_EV_RXRDY, 0);
    chk("R7 all drained", rx_q.size(), 0);
    // R9 tasks
    wr(A_STOP_RX, 1);  port_chk("R9 stop rx", rx_ready, 0);
    rd_chk("R9 rxto", A_EV_RXTO, 1);
    wr(A_EV_RXTO, 0);
    wr(A_START_RX, 2); port_chk("R9 value 2 ignored", rx_ready, 0);
    wr(A_START_RX, 1); port_chk("R9 restart", rx_ready, 1);
    wr(A_SUSPEND, 1);  port_chk("R9 suspend rx", rx_ready, 0);
    rd_chk("R9 suspend rxto", A_EV_RXTO, 1);
    send_tx(8'h42, 0); port_chk("R9 suspend tx", tx_valid, 0);
    wr(A_EV_RXTO, 0);
    // R10 break
    wr(A_IRQ_SET, 4);
    @(negedge clk); brk = 1; @(posedge clk); #1 brk = 0;
    port_chk("R10 irq", irq, 1);
    rd_chk("R10 errsrc", A_ERR_SRC, 3);
    rd_chk("R10 error event", A_EV_ERROR, 1);
    wr(A_ERR_SRC, 1); rd_chk("R10 w1c bit0", A_ERR_SRC, 2);
    wr(A_ERR_SRC, 2); rd_chk("R10 w1c bit1", A_ERR_SRC, 0);
    wr(A_EV_ERROR, 0); port_chk("R11 error cleared", irq, 0);
    wr(A_IRQ_MASK, 0);
    // R2 disable stops everything
    wr(A_START_RX, 1); wr(A_START_TX, 1);
    port_chk("R2 running", rx_ready, 1);
    wr(A_ENABLE, 0);
    port_chk("R2 rx stopped", rx_ready, 0);
    rd_chk("R3 disabled read", A_ENABLE, 0);
    wr(A_ENABLE, 4);
    rd_chk("R2 rxto", A_EV_RXTO, 1);
    send_tx(8'h5A, 0); port_chk("R2 tx stopped", tx_valid, 0);
    repeat (2) @(posedge clk);
    chk("R6 scoreboard empty", tx_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule